// File: doc/BRIEF.md
# Fractional Clock Divider with Triangular Frequency Sweep

This block divides a fast source clock by a ratio made of an integer part plus a fraction held as numerator over denominator. Each output period is either the floor or the ceiling of that ratio. An accumulator adds the numerator once per output period, and an overflow past the denominator lengthens that period by one source cycle. Over any run of denominator-many periods, the total length is exactly the programmed ratio times the period count.

A frequency sweep can be laid over the ratio to spread the output spectrum. The sweep is a triangular offset on the numerator, in units of one denominator step. It moves by a programmed step once every programmed number of source cycles and turns back at its limits. Down mode only lengthens the period. Center mode is built as a nominal ratio lowered by the depth, plus a down-style sweep of twice the depth, so the swing is symmetric about the nominal point. A global kill input turns the sweep off. A start-up phase delay, counted in source cycles, applies only while the sweep is off.

A synchronous reset or restart clears the accumulator and the sweep. It loads the phase delay, and the sweep starts again from its nominal point. Configuration inputs are expected to change only together with a restart.

Top module: `fdiv_ssc_top`

## Requirements
- R1: With the sweep inactive and the accumulator starting at zero, output period k (k = 0, 1, 2, ... in source cycles) equals div_int + floor((k+1)*div_num/div_den) - floor(k*div_num/div_den), so every period is the floor or the ceiling of the ratio. Assumes div_int >= 3, div_den >= 1, div_num < div_den.
- R2: With the sweep inactive, any div_den consecutive periods starting at a period index that is a multiple of div_den add up to exactly div_int*div_den + div_num source cycles.
- R3: In a period of P cycles, clk_out is high for the first ceil(P/2) cycles and low for the rest. tc_pulse is high for exactly one cycle, the last cycle of each period.
- R4: With the sweep inactive, the first tc_pulse comes D + P0 cycles after restart (or rst) is released, where D is phase_skew and P0 is the first period.
- R5: With the sweep active (sweep_en=1, sweep_kill=0), phase_skew has no effect: the first tc_pulse comes P0 cycles after release.
- R6: sweep_mode=0 selects center mode. The numerator offset stays within -sweep_depth to +sweep_depth (units of 1/div_den). With div_int=4, div_num=0, div_den=16 and depth 8, periods stay within 3..5 and both 3 and 5 occur.
- R7: sweep_mode=1 selects down mode. The offset stays within 0 to +sweep_depth, so no period is shorter than the nominal floor and the average period grows.
- R8: The offset starts at nominal. It changes only once every sweep_rate source cycles, by at most sweep_step each time, and reverses direction at each limit. The sweep therefore reaches its two extremes repeatedly.
- R9: sweep_kill=1 forces the sweep off even when sweep_en=1. Periods then follow R1 exactly and phase_skew applies.
- R10: Restart clears the accumulator mid-run, so the period sequence starts again at k=0 of R1.
- R11: While rst is high, clk_out and tc_pulse are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast source clock |
| rst | input | 1 | Synchronous active-high reset |
| restart | input | 1 | Synchronous divider restart, same effect as reset |
| div_int | input | IW | Integer part of the divide ratio (>= 3) |
| div_num | input | FW | Fraction numerator (< div_den) |
| div_den | input | FW | Fraction denominator (>= 1) |
| sweep_en | input | 1 | Enables the frequency sweep on this divider |
| sweep_kill | input | 1 | Global sweep disable shared by all dividers |
| sweep_mode | input | 1 | 0 = center sweep, 1 = down sweep |
| sweep_depth | input | FW | Sweep limit in numerator units (< div_den) |
| sweep_step | input | FW | Offset change per sweep tick |
| sweep_rate | input | RW | Source cycles per sweep tick |
| phase_skew | input | PW | Start-up delay in source cycles when the sweep is off |
| clk_out | output | 1 | Divided clock |
| tc_pulse | output | 1 | One-cycle pulse on the last cycle of each output period |

## Verification
A corrupted accumulator appears within one output period: a period one cycle too long or too short, compared against the exact floor-difference sequence. It also breaks the sum over one denominator cycle. A wrong count or duty threshold in the period generator shows on the next clk_out high time or tc_pulse spacing. A sweep that fails to turn back, or drifts past its limits, shows within a few hundred source cycles: periods fall outside the permitted set, or one extreme never returns.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
    localparam int DEF_IW = 8;
    localparam int DEF_FW = 8;
    localparam int DEF_RW = 12;
    localparam int DEF_PW = 8;

    typedef enum logic {
        SWEEP_CENTER = 1'b0,
        SWEEP_DOWN   = 1'b1
    } sweep_mode_e;

    typedef enum logic [1:0] {
        FIX_NONE   = 2'd0,
        FIX_BORROW = 2'd1,
        FIX_CARRY  = 2'd2
    } frac_fix_e;
endpackage

// File: rtl/fdiv_sweep.sv
module fdiv_sweep #(
    parameter int FW = fdiv_pkg::DEF_FW,
    parameter int RW = fdiv_pkg::DEF_RW
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    restart,
    input  logic                    active,
    input  fdiv_pkg::sweep_mode_e   mode,
    input  logic [FW-1:0]           depth,
    input  logic [FW-1:0]           step,
    input  logic [RW-1:0]           rate,
    output logic signed [FW+1:0]    offset
);
    localparam int UW = FW + 1;

    logic [RW-1:0] tick_cnt;
    logic [UW-1:0] pos;
    logic [UW-1:0] span;
    logic [UW-1:0] bias;
    logic [UW:0]   pos_up;
    logic          rising;
    logic          tick;

    always_comb begin
        span   = (mode == fdiv_pkg::SWEEP_DOWN) ? {1'b0, depth} : {depth, 1'b0};
        bias   = (mode == fdiv_pkg::SWEEP_DOWN) ? '0 : {1'b0, depth};
        tick   = ({1'b0, tick_cnt} + 1'b1) >= {1'b0, rate};
        pos_up = {1'b0, pos} + {2'b0, step};
    end

    always_ff @(posedge clk) begin
        if (rst || restart || !active) begin
            tick_cnt <= '0;
            pos      <= bias;
            rising   <= 1'b1;
        end else if (tick) begin
            tick_cnt <= '0;
            if (rising) begin
                if (pos_up >= {1'b0, span}) begin
                    pos    <= span;
                    rising <= 1'b0;
                end else begin
                    pos <= pos_up[UW-1:0];
                end
            end else begin
                if (pos <= {1'b0, step}) begin
                    pos    <= '0;
                    rising <= 1'b1;
                end else begin
                    pos <= pos - {1'b0, step};
                end
            end
        end else begin
            tick_cnt <= tick_cnt + 1'b1;
        end
    end

    assign offset = active ? ($signed({1'b0, pos}) - $signed({1'b0, bias})) : '0;

    AST_SWEEP_IN_SPAN: assert property (@(posedge clk) disable iff (rst || restart)
        pos <= span) else $error("sweep position beyond span"); // R6
    AST_SWEEP_HOLD: assert property (@(posedge clk) disable iff (rst || restart)
        (active && !tick) |=> $stable(pos)) else $error("sweep moved off tick"); // R8
    AST_SWEEP_STEP: assert property (@(posedge clk) disable iff (rst || restart)
        (active && tick) |=> (((pos >= $past(pos)) ? (pos - $past(pos)) : ($past(pos) - pos)) <= {1'b0, step}))
        else $error("sweep jumped more than one step"); // R8
endmodule

// File: rtl/fdiv_ratio.sv
module fdiv_ratio #(
    parameter int IW = fdiv_pkg::DEF_IW,
    parameter int FW = fdiv_pkg::DEF_FW
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 restart,
    input  logic                 load,
    input  logic [IW-1:0]        int_part,
    input  logic [FW-1:0]        num,
    input  logic [FW-1:0]        den,
    input  logic signed [FW+1:0] offset,
    output logic [IW:0]          period
);
    localparam int SW = FW + 2;

    logic [FW-1:0]        acc;
    logic signed [SW-1:0] eff;
    logic signed [SW-1:0] den_s;
    logic [SW-1:0]        frac_fixed;
    logic [IW:0]          base;
    logic [FW:0]          sum;
    logic [FW:0]          sum_wrap;
    logic                 carry;
    fdiv_pkg::frac_fix_e  fix;

    always_comb begin
        den_s = $signed({2'b0, den});
        eff   = $signed({2'b0, num}) + offset;
        if (eff < 0)
            fix = fdiv_pkg::FIX_BORROW;
        else if (eff >= den_s)
            fix = fdiv_pkg::FIX_CARRY;
        else
            fix = fdiv_pkg::FIX_NONE;
        case (fix)
            fdiv_pkg::FIX_BORROW: begin
                base       = {1'b0, int_part} - 1'b1;
                frac_fixed = eff + den_s;
            end
            fdiv_pkg::FIX_CARRY: begin
                base       = {1'b0, int_part} + 1'b1;
                frac_fixed = eff - den_s;
            end
            default: begin
                base       = {1'b0, int_part};
                frac_fixed = eff;
            end
        endcase
        sum      = {1'b0, acc} + frac_fixed[FW:0];
        carry    = sum >= {1'b0, den};
        sum_wrap = sum - {1'b0, den};
        period   = base + {{IW{1'b0}}, carry};
    end

    always_ff @(posedge clk) begin
        if (rst || restart)
            acc <= '0;
        else if (load)
            acc <= carry ? sum_wrap[FW-1:0] : sum[FW-1:0];
    end

    AST_ACC_BELOW_DEN: assert property (@(posedge clk) disable iff (rst || restart)
        acc < den) else $error("accumulator not below denominator"); // R1
    AST_PERIOD_NEAR: assert property (@(posedge clk) disable iff (rst || restart)
        load |-> (({1'b0, int_part} <= period + 1'b1) && (period <= {1'b0, int_part} + 2'd2)))
        else $error("period outside swept range"); // R6
endmodule

// File: rtl/fdiv_pulse.sv
module fdiv_pulse #(
    parameter int IW = fdiv_pkg::DEF_IW,
    parameter int PW = fdiv_pkg::DEF_PW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic [PW-1:0] phase_init,
    input  logic [IW:0]   period,
    output logic          load,
    output logic          clk_out,
    output logic          tc
);
    logic [IW:0]   cnt;
    logic [IW:0]   half;
    logic [PW-1:0] hold;
    logic          started;

    assign load    = started ? (cnt == '0) : (hold == '0);
    assign tc      = started && (cnt == '0);
    assign clk_out = started && (cnt >= half);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            started <= 1'b0;
            cnt     <= '0;
            half    <= '0;
            hold    <= phase_init;
        end else if (load) begin
            started <= 1'b1;
            cnt     <= period - 1'b1;
            half    <= period >> 1;
        end else if (started) begin
            cnt <= cnt - 1'b1;
        end else begin
            hold <= hold - 1'b1;
        end
    end

    AST_TC_THEN_HIGH: assert property (@(posedge clk) disable iff (rst || restart)
        tc |=> clk_out) else $error("new period did not start high"); // R3
    AST_TC_SINGLE: assert property (@(posedge clk) disable iff (rst || restart)
        tc |=> !tc) else $error("terminal pulse wider than one cycle"); // R3
endmodule

// File: rtl/fdiv_ssc_top.sv
module fdiv_ssc_top #(
    parameter int IW = fdiv_pkg::DEF_IW,
    parameter int FW = fdiv_pkg::DEF_FW,
    parameter int RW = fdiv_pkg::DEF_RW,
    parameter int PW = fdiv_pkg::DEF_PW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic [IW-1:0] div_int,
    input  logic [FW-1:0] div_num,
    input  logic [FW-1:0] div_den,
    input  logic          sweep_en,
    input  logic          sweep_kill,
    input  logic          sweep_mode,
    input  logic [FW-1:0] sweep_depth,
    input  logic [FW-1:0] sweep_step,
    input  logic [RW-1:0] sweep_rate,
    input  logic [PW-1:0] phase_skew,
    output logic          clk_out,
    output logic          tc_pulse
);
    logic                 active;
    logic [PW-1:0]        phase_sel;
    logic signed [FW+1:0] offset;
    logic [IW:0]          period;
    logic                 load;

    assign active    = sweep_en && !sweep_kill;
    assign phase_sel = active ? '0 : phase_skew;

    fdiv_sweep #(.FW(FW), .RW(RW)) sweep_i (
        .clk(clk), .rst(rst), .restart(restart), .active(active),
        .mode(fdiv_pkg::sweep_mode_e'(sweep_mode)),
        .depth(sweep_depth), .step(sweep_step), .rate(sweep_rate),
        .offset(offset)
    );

    fdiv_ratio #(.IW(IW), .FW(FW)) ratio_i (
        .clk(clk), .rst(rst), .restart(restart), .load(load),
        .int_part(div_int), .num(div_num), .den(div_den),
        .offset(offset), .period(period)
    );

    fdiv_pulse #(.IW(IW), .PW(PW)) pulse_i (
        .clk(clk), .rst(rst), .restart(restart), .phase_init(phase_sel),
        .period(period), .load(load), .clk_out(clk_out), .tc(tc_pulse)
    );
endmodule

// File: tb/fdiv_ssc_top_tb_top.sv
`timescale 1ns/1ps
module fdiv_ssc_top_tb_top;
    localparam int IW = 8;
    localparam int FW = 8;
    localparam int RW = 12;
    localparam int PW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          restart = 1'b0;
    logic [IW-1:0] div_int = 8'd4;
    logic [FW-1:0] div_num = 8'd0;
    logic [FW-1:0] div_den = 8'd1;
    logic          sweep_en = 1'b0;
    logic          sweep_kill = 1'b0;
    logic          sweep_mode = 1'b0;
    logic [FW-1:0] sweep_depth = 8'd0;
    logic [FW-1:0] sweep_step = 8'd0;
    logic [RW-1:0] sweep_rate = 12'd1;
    logic [PW-1:0] phase_skew = 8'd2;
    logic          clk_out;
    logic          tc_pulse;

    int errors = 0;
    int checks = 0;
    int plen [0:255];
    int phi  [0:255];

    always #2.5 clk = ~clk;

    fdiv_ssc_top #(.IW(IW), .FW(FW), .RW(RW), .PW(PW)) dut_i (
        .clk(clk), .rst(rst), .restart(restart),
        .div_int(div_int), .div_num(div_num), .div_den(div_den),
        .sweep_en(sweep_en), .sweep_kill(sweep_kill), .sweep_mode(sweep_mode),
        .sweep_depth(sweep_depth), .sweep_step(sweep_step), .sweep_rate(sweep_rate),
        .phase_skew(phase_skew), .clk_out(clk_out), .tc_pulse(tc_pulse)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic setup(input int i, input int n, input int d, input bit en, input bit kill,
                         input bit md, input int dep, input int st, input int rt, input int ph);
        @(negedge clk);
        div_int     = IW'(i);
        div_num     = FW'(n);
        div_den     = FW'(d);
        sweep_en    = en;
        sweep_kill  = kill;
        sweep_mode  = md;
        sweep_depth = FW'(dep);
        sweep_step  = FW'(st);
        sweep_rate  = RW'(rt);
        phase_skew  = PW'(ph);
        restart     = 1'b1;
        @(negedge clk);
        restart = 1'b0;
    endtask

    task automatic first_tc(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!tc_pulse && n < 2000);
    endtask

    task automatic collect(input int cnt);
        int len;
        int hi;
        int k;
        len = 0;
        hi = 0;
        k = 0;
        while (k < cnt) begin
            @(negedge clk);
            len++;
            if (clk_out) hi++;
            if (tc_pulse) begin
                plen[k] = len;
                phi[k] = hi;
                k++;
                len = 0;
                hi = 0;
            end
        end
    endtask

    function automatic int exp_period(input int i, input int n, input int d, input int j);
        return i + ((j + 1) * n) / d - (j * n) / d;
    endfunction

    task automatic check_sequence(input int i, input int n, input int d, input int cnt, input string req);
        for (int k = 0; k < cnt; k++) begin
            check(plen[k] == exp_period(i, n, d, k + 1), req, plen[k], exp_period(i, n, d, k + 1));
            check(phi[k] == (plen[k] + 1) / 2, "R3", phi[k], (plen[k] + 1) / 2);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(100000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        int f;
        int tot;
        int bad;
        int ext;
        int swaps;
        bit saw3;
        bit saw5;

        repeat (4) @(negedge clk);
        check(clk_out == 1'b0, "R11", int'(clk_out), 0);
        check(tc_pulse == 1'b0, "R11", int'(tc_pulse), 0);
        rst = 1'b0;
        first_tc(f);
        check(f == 6, "R4", f, 6);

        // R1 R2 R3: sweep over small ratios
        for (int i = 3; i <= 5; i++) begin
            for (int d = 1; d <= 6; d++) begin
                for (int n = 0; n < d; n++) begin
                    setup(i, n, d, 0, 0, 0, 0, 0, 1, 0);
                    first_tc(f);
                    check(f == i, "R1", f, i);
                    collect(2 * d + 1);
                    check_sequence(i, n, d, 2 * d + 1, "R1");
                    tot = 0;
                    for (int k = d - 1; k < 2 * d - 1; k++) tot += plen[k];
                    check(tot == i * d + n, "R2", tot, i * d + n);
                end
            end
        end
        for (int n = 1; n < 16; n += 7) begin
            setup(4, n, 16, 0, 0, 0, 0, 0, 1, 0);
            first_tc(f);
            collect(40);
            check_sequence(4, n, 16, 40, "R1");
            tot = 0;
            for (int k = 15; k < 31; k++) tot += plen[k];
            check(tot == 64 + n, "R2", tot, 64 + n);
        end

        // R4: phase delay with sweep off
        for (int d = 0; d < 220; d += 55) begin
            setup(4, 3, 5, 0, 0, 0, 0, 0, 1, d);
            first_tc(f);
            check(f == d + 4, "R4", f, d + 4);
        end

        // R5: phase ignored while sweep active
        setup(4, 0, 16, 1, 0, 0, 8, 2, 3, 9);
        first_tc(f);
        check(f == 4, "R5", f, 4);

        // R9: kill forces sweep off, phase applies again
        setup(4, 0, 16, 1, 1, 0, 8, 2, 3, 9);
        first_tc(f);
        check(f == 13, "R9", f, 13);
        collect(40);
        bad = 0;
        for (int k = 0; k < 40; k++) if (plen[k] != 4) bad++;
        check(bad == 0, "R9", bad, 0);
        setup(4, 5, 16, 1, 1, 1, 8, 2, 3, 0);
        first_tc(f);
        collect(34);
        check_sequence(4, 5, 16, 34, "R9");

        // R6 R8: center sweep
        setup(4, 0, 16, 1, 0, 0, 8, 2, 3, 0);
        first_tc(f);
        collect(200);
        bad = 0; saw3 = 0; saw5 = 0; ext = 0; swaps = 0;
        for (int k = 0; k < 200; k++) begin
            if (plen[k] < 3 || plen[k] > 5) bad++;
            if (plen[k] == 3) begin
                saw3 = 1;
                if (ext == 5) swaps++;
                ext = 3;
            end
            if (plen[k] == 5) begin
                saw5 = 1;
                if (ext == 3) swaps++;
                ext = 5;
            end
        end
        check(bad == 0, "R6", bad, 0);
        check(saw3 && saw5, "R6", int'(saw3) + 2 * int'(saw5), 3);
        check(swaps >= 3, "R8", swaps, 3);

        // R7: down sweep
        setup(4, 0, 16, 1, 0, 1, 8, 2, 3, 0);
        first_tc(f);
        collect(200);
        bad = 0; saw5 = 0; tot = 0;
        for (int k = 0; k < 200; k++) begin
            if (plen[k] < 4 || plen[k] > 5) bad++;
            if (plen[k] == 5) saw5 = 1;
            tot += plen[k];
        end
        check(bad == 0, "R7", bad, 0);
        check(saw5, "R7", int'(saw5), 1);
        check(tot > 800, "R7", tot, 801);

        // R10: restart clears accumulator mid-run
        setup(3, 4, 5, 0, 0, 0, 0, 0, 1, 0);
        first_tc(f);
        collect(3);
        setup(3, 4, 5, 0, 0, 0, 0, 0, 1, 0);
        first_tc(f);
        check(f == 3, "R10", f, 3);
        collect(10);
        check_sequence(3, 4, 5, 10, "R10");

        finish_run();
    end
endmodule